// File: doc/BRIEF.md
# Differential Data Value Encoder

This block compresses a stream of data addresses or data values by turning each accepted word into a signed difference from the word accepted before it. The difference is carried as a sign bit and an absolute magnitude. The block then picks the narrowest of three fixed magnitude fields that can hold it. When the magnitude is too large for the widest field, the block sends the current word in full instead. Each encoded result has a 2-bit width header, a sign bit, a right-aligned payload and the total length of the result in bits. A later packing stage uses that length to pack results into memory words.

A flush input starts a new trace segment by clearing the reference word to zero. This lets a decoder that joins at a segment boundary rebuild every value without any earlier history. A datum presented in the same cycle as a flush is still encoded, measured against zero, and becomes the first reference of the new segment. Each result appears exactly one clock after its input.

Top module: `delta_value_encoder`

## Requirements
- R1: After reset `valid_o` is 0, and the reference word is 0, so the first accepted datum is encoded as its difference from 0.
- R2: For an accepted datum `d` and reference `p`, the payload is |d − p| and `sign_o` is 1 exactly when d < p (for p=3, d=5: sign 0, payload 2).
- R3: The header is 2'b00 for magnitudes 0..15, 2'b01 for 16..255 and 2'b10 for 256..65535. The narrowest fitting field is always chosen.
- R4: When the magnitude exceeds 65535, the header is 2'b11, the payload is the full current datum and `sign_o` is 0.
- R5: `len_o` equals 3 plus the payload field width: 7, 11, 19 or 35 for headers 00, 01, 10 and 11.
- R6: `valid_o` is asserted in the cycle after each cycle with `valid_i` high, and only then.
- R7: The reference changes only when a datum is accepted. Cycles with `valid_i` low leave it unchanged, whatever `data_i` holds in those cycles.
- R8: `flush_i` clears the reference to 0. A datum accepted in the same cycle as a flush is encoded against 0 and is not dropped.
- R9: Payload bits above the selected field width are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Datum strobe |
| data_i | input | 32 | Address or value to encode |
| flush_i | input | 1 | Start a new segment (reference cleared to 0) |
| valid_o | output | 1 | Encoded result valid |
| hdr_o | output | 2 | Field width header |
| sign_o | output | 1 | 1 when datum is below reference |
| payload_o | output | 32 | Magnitude, or full datum for header 11 |
| len_o | output | 6 | Result length in bits |

## Verification
The assertions check several properties on every cycle. They check the one-cycle valid latency and the tie between header and length. They check that payload bits outside the field are clear. They check that a field wider than needed is never used, because a wider header needs a nonzero upper part in its payload. They also check that a full-value result carries the datum of the previous cycle with a zero sign. Whether a magnitude and sign are correct depends on the reference held across idle cycles and flushes, so only the bench scenarios can show this. The bench tracks its own reference through long streams of deltas placed at every field boundary and on both sides of zero. It also runs idle gaps with changing data, flushes with and without a datum in the same cycle, and a difference that wraps across the full 32-bit range.

// File: rtl/delta_enc_pkg.sv
package delta_enc_pkg;
  typedef enum logic [1:0] {
    HDR_NARROW = 2'b00,
    HDR_MID    = 2'b01,
    HDR_WIDE   = 2'b10,
    HDR_FULL   = 2'b11
  } hdr_e;

  localparam int unsigned PREFIX_W = 3;  // header + sign
endpackage

// File: rtl/delta_sub.sv
module delta_sub #(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] ref_i,
  input  logic [DATA_W-1:0] cur_i,
  output logic              neg_o,
  output logic [DATA_W-1:0] mag_o
);
  always_comb begin
    neg_o = cur_i < ref_i;
    mag_o = neg_o ? (ref_i - cur_i) : (cur_i - ref_i);
  end
endmodule

// File: rtl/delta_width_sel.sv
module delta_width_sel
  import delta_enc_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned NARROW_W = 4,
  parameter int unsigned MID_W    = 8,
  parameter int unsigned WIDE_W   = 16,
  parameter int unsigned LEN_W    = 6
) (
  input  logic [DATA_W-1:0] mag_i,
  input  logic [DATA_W-1:0] cur_i,
  input  logic              neg_i,
  output hdr_e              hdr_o,
  output logic              sign_o,
  output logic [DATA_W-1:0] payload_o,
  output logic [LEN_W-1:0]  len_o
);
  localparam logic [LEN_W-1:0] LEN_NARROW = LEN_W'(PREFIX_W + NARROW_W);
  localparam logic [LEN_W-1:0] LEN_MID    = LEN_W'(PREFIX_W + MID_W);
  localparam logic [LEN_W-1:0] LEN_WIDE   = LEN_W'(PREFIX_W + WIDE_W);
  localparam logic [LEN_W-1:0] LEN_FULL   = LEN_W'(PREFIX_W + DATA_W);

  logic fit_narrow, fit_mid, fit_wide;

  always_comb begin
    fit_narrow = (mag_i >> NARROW_W) == '0;
    fit_mid    = (mag_i >> MID_W) == '0;
    fit_wide   = (mag_i >> WIDE_W) == '0;

    hdr_o     = HDR_FULL;
    sign_o    = 1'b0;
    payload_o = cur_i;
    len_o     = LEN_FULL;
    if (fit_narrow) begin
      hdr_o = HDR_NARROW; sign_o = neg_i; payload_o = mag_i; len_o = LEN_NARROW;
    end else if (fit_mid) begin
      hdr_o = HDR_MID;    sign_o = neg_i; payload_o = mag_i; len_o = LEN_MID;
    end else if (fit_wide) begin
      hdr_o = HDR_WIDE;   sign_o = neg_i; payload_o = mag_i; len_o = LEN_WIDE;
    end
  end
endmodule

// File: rtl/delta_value_encoder.sv
module delta_value_encoder
  import delta_enc_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned NARROW_W = 4,
  parameter int unsigned MID_W    = 8,
  parameter int unsigned WIDE_W   = 16,
  localparam int unsigned LEN_W   = $clog2(DATA_W + PREFIX_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              flush_i,
  output logic              valid_o,
  output logic [1:0]        hdr_o,
  output logic              sign_o,
  output logic [DATA_W-1:0] payload_o,
  output logic [LEN_W-1:0]  len_o
);
  logic [DATA_W-1:0] ref_q, ref_eff;
  logic              neg;
  logic [DATA_W-1:0] mag;
  hdr_e              hdr_d;
  logic              sign_d;
  logic [DATA_W-1:0] payload_d;
  logic [LEN_W-1:0]  len_d;

  // flush takes effect before a same-cycle datum
  assign ref_eff = flush_i ? '0 : ref_q;

  delta_sub #(.DATA_W(DATA_W)) sub_i (
    .ref_i (ref_eff),
    .cur_i (data_i),
    .neg_o (neg),
    .mag_o (mag)
  );

  delta_width_sel #(
    .DATA_W  (DATA_W),
    .NARROW_W(NARROW_W),
    .MID_W   (MID_W),
    .WIDE_W  (WIDE_W),
    .LEN_W   (LEN_W)
  ) sel_i (
    .mag_i    (mag),
    .cur_i    (data_i),
    .neg_i    (neg),
    .hdr_o    (hdr_d),
    .sign_o   (sign_d),
    .payload_o(payload_d),
    .len_o    (len_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_q <= '0;
    end else if (valid_i) begin
      ref_q <= data_i;
    end else if (flush_i) begin
      ref_q <= '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      hdr_o     <= 2'b00;
      sign_o    <= 1'b0;
      payload_o <= '0;
      len_o     <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        hdr_o     <= hdr_d;
        sign_o    <= sign_d;
        payload_o <= payload_d;
        len_o     <= len_d;
      end
    end
  end
endmodule

// File: rtl/delta_value_encoder_chk.sv
module delta_value_encoder_chk #(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned NARROW_W = 4,
  parameter int unsigned MID_W    = 8,
  parameter int unsigned WIDE_W   = 16,
  parameter int unsigned LEN_W    = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [DATA_W-1:0] data_i,
  input logic              valid_o,
  input logic [1:0]        hdr_o,
  input logic              sign_o,
  input logic [DATA_W-1:0] payload_o,
  input logic [LEN_W-1:0]  len_o
);
  // R6
  valid_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == $past(valid_i));

  // R5
  len_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> len_o == LEN_W'(3 + (hdr_o == 2'b00 ? NARROW_W :
                                     hdr_o == 2'b01 ? MID_W :
                                     hdr_o == 2'b10 ? WIDE_W : DATA_W)));

  // R9
  field_clean_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && hdr_o != 2'b11) |->
      (payload_o >> (hdr_o == 2'b00 ? NARROW_W : hdr_o == 2'b01 ? MID_W : WIDE_W)) == '0);

  // R3
  mid_minimal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && hdr_o == 2'b01) |-> (payload_o >> NARROW_W) != '0);

  // R3
  wide_minimal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && hdr_o == 2'b10) |-> (payload_o >> MID_W) != '0);

  // R4
  full_value_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && hdr_o == 2'b11) |-> (payload_o == $past(data_i) && !sign_o));

  // R2
  zero_unsigned_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && hdr_o != 2'b11 && payload_o == '0) |-> !sign_o);
endmodule

bind delta_value_encoder delta_value_encoder_chk #(
  .DATA_W  (DATA_W),
  .NARROW_W(NARROW_W),
  .MID_W   (MID_W),
  .WIDE_W  (WIDE_W),
  .LEN_W   (LEN_W)
) chk_i (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .valid_i  (valid_i),
  .data_i   (data_i),
  .valid_o  (valid_o),
  .hdr_o    (hdr_o),
  .sign_o   (sign_o),
  .payload_o(payload_o),
  .len_o    (len_o)
);

// File: tb/delta_value_encoder_tb_top.sv
module delta_value_encoder_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] data_i = '0;
  logic        flush_i = 1'b0;
  logic        valid_o;
  logic [1:0]  hdr_o;
  logic        sign_o;
  logic [31:0] payload_o;
  logic [5:0]  len_o;

  int errors = 0;
  int checks = 0;
  logic [31:0] model_ref = '0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  delta_value_encoder dut_i (
    .clk_i, .rst_ni, .valid_i, .data_i, .flush_i,
    .valid_o, .hdr_o, .sign_o, .payload_o, .len_o
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [31:0] d, input logic fl, input string ctx);
    logic [31:0] p, mag, pay;
    logic        neg;
    logic [1:0]  hdr;
    int          w;
    @(negedge clk_i);
    valid_i = 1'b1; data_i = d; flush_i = fl;
    p   = fl ? 32'd0 : model_ref;
    neg = d < p;
    mag = neg ? p - d : d - p;
    if (mag <= 32'd15)         begin hdr = 2'b00; w = 4;  end
    else if (mag <= 32'd255)   begin hdr = 2'b01; w = 8;  end
    else if (mag <= 32'd65535) begin hdr = 2'b10; w = 16; end
    else                       begin hdr = 2'b11; w = 32; end
    pay = (hdr == 2'b11) ? d : mag;
    if (hdr == 2'b11) neg = 1'b0;
    model_ref = d;
    @(negedge clk_i);
    valid_i = 1'b0; flush_i = 1'b0;
    check({ctx, " R6 valid"}, 64'(valid_o), 64'd1);
    check({ctx, " R3 header"}, 64'(hdr_o), 64'(hdr));
    check({ctx, " R2 sign"}, 64'(sign_o), 64'(neg));
    check({ctx, " R2 payload"}, 64'(payload_o), 64'(pay));
    check({ctx, " R5 length"}, 64'(len_o), 64'(3 + w));
    if (hdr == 2'b11) check({ctx, " R4 full value"}, 64'(payload_o), 64'(d));
    else check({ctx, " R9 upper bits"}, 64'(payload_o >> w), 64'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++; checks++;
    $display("FAIL watchdog R6: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1 reset valid", 64'(valid_o), 64'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 idle after reset", 64'(valid_o), 64'd0);
    send(32'd3, 1'b0, "R1 first vs zero");
    send(32'd5, 1'b0, "R2 plus two");
    send(32'd5, 1'b0, "R2 zero delta");
    send(32'd3, 1'b0, "R2 minus two");

    // boundary deltas at every power of two, both signs
    for (int k = 0; k < 32; k++) begin
      for (int s = 0; s < 2; s++) begin
        logic [31:0] dl;
        dl = (32'd1 << k) - 32'd1;
        send(s ? model_ref - dl : model_ref + dl, 1'b0, "R3 sweep below");
        dl = 32'd1 << k;
        send(s ? model_ref - dl : model_ref + dl, 1'b0, "R3 sweep at");
      end
    end
    // near-exhaustive small deltas
    for (int m = 0; m < 300; m++)
      send(model_ref + ((m % 2) ? -32'(m) : 32'(m)), 1'b0, "R3 small");

    send(32'hFFFF_FFFF, 1'b0, "R4 large");
    send(32'h0000_0000, 1'b0, "R4 wrap");
    send(32'h0001_0000, 1'b0, "R4 exact 65536");
    send(32'h0000_0001, 1'b0, "R3 exact 65535");

    // idle cycles with changing data
    for (int i = 0; i < 5; i++) begin
      @(negedge clk_i);
      data_i = 32'h1234_0000 + 32'(i);
      @(negedge clk_i);
      check("R7 idle no valid", 64'(valid_o), 64'd0);
    end
    send(32'h0000_0009, 1'b0, "R7 after idle");

    // flush alone
    send(32'h4000_0000, 1'b0, "R8 setup");
    @(negedge clk_i);
    flush_i = 1'b1;
    model_ref = 32'd0;
    @(negedge clk_i);
    flush_i = 1'b0;
    check("R8 flush no output", 64'(valid_o), 64'd0);
    send(32'h0000_0007, 1'b0, "R8 after flush");

    // flush with datum
    send(32'h8000_0000, 1'b0, "R8 setup2");
    send(32'h0000_0020, 1'b1, "R8 flush same cycle");
    send(32'h0000_0021, 1'b0, "R8 next in segment");

    @(negedge clk_i);
    check("R6 no spurious valid", 64'(valid_o), 64'd0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule